// File: doc/BRIEF.md
# Four-Phase Handshake Pipeline Stage

This block is one stage of a self-timed pipeline, modelled in clocked RTL with a sampling clock. It holds a stage controller, an operand register and a dual-rail logic operator that precharges and then evaluates. Stages are chained: one stage's request output drives the next stage's request input, and the acknowledge runs the other way. Handshakes use the four-phase return-to-zero protocol. A stage takes in a new operand only on the join of three conditions. The previous stage must be requesting. The stage's own operator must be idle and precharged. The next stage must have fully acknowledged the last result.

The operator computes `operand XOR KEY`, one bit per bit position. Each result bit is a rail pair that starts at 11 in precharge. It resolves to 10 for a one or to 01 for a zero. When `op_slow` is low, the operator resolves one bit per sampled cycle, starting from the least significant bit. When `op_slow` is high, it pauses. This models a variable evaluation delay. Completion is taken from the rails themselves: the result is ready when every pair has diverged. The output word is the true rail of each pair. It is valid only while ready is high.

Top module: `hs_pipe_stage`

## Requirements
- R1: After reset, ack_out, req_out, latch_en, op_eval and op_ready are all 0, and data_out is all ones because every rail pair is precharged to 11.
- R2: latch_en is 1 only when all of these hold: req_in is 1, ack_out is 0, req_out is 0, ack_in is 0, op_eval is 0 and every rail pair is 11. When any of them fails, ack_out stays 0 even while req_in is held high.
- R3: In the cycle after latch_en is 1, ack_out and op_eval are both 1, and the operand register holds the data_in value sampled with latch_en.
- R4: req_out rises only after a cycle in which op_ready was 1 and ack_in was 0. Once raised, req_out stays 1 until ack_in is seen at 1.
- R5: When req_out is 1 and ack_in has not yet risen, op_ready is 1 and data_out equals data_in XOR KEY for the latched operand.
- R6: req_out falls only after a cycle in which ack_in was 1 and all rail pairs had returned to 11. op_eval drops to 0 one cycle after req_out and ack_in are both 1.
- R7: ack_out falls only after a cycle in which req_in was 0, and it stays 1 while req_in stays 1.
- R8: No rail pair is ever 00, and a resolved pair never changes directly between 10 and 01. op_ready is 1 exactly when every pair differs.
- R9: With op_slow low throughout, op_ready rises exactly W cycles after op_eval rises. While op_slow and op_eval are both 1, the rails do not change in the following cycle.
- R10: In a chain of stages, every word reaches the end exactly once, in the order it was sent, transformed by each stage's KEY in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 1 | Request from the previous stage |
| ack_out | output | 1 | Acknowledge to the previous stage |
| data_in | input | W | Operand offered by the previous stage |
| req_out | output | 1 | Request to the next stage |
| ack_in | input | 1 | Acknowledge from the next stage |
| data_out | output | W | True rails of the operator result; valid while op_ready is 1 |
| op_slow | input | 1 | Pauses operator evaluation in this cycle |
| latch_en | output | 1 | Operand register load enable (the join of the three conditions) |
| op_eval | output | 1 | 1 = evaluate, 0 = precharge |
| op_ready | output | 1 | Completion: all rail pairs have diverged |

## Verification
Some properties are checked on every cycle. These are the protocol ordering at both edges of the stage: the three-way join before a latch, the rise and hold of req_out and ack_out, and their return-to-zero preconditions. They also include the rail legality rules: no 00 pair, no direct swap between 10 and 01, and rails frozen while the operator is paused. Other behaviour shows up only in bench scenarios. This covers the result values and their order through three chained stages, and the exact evaluation latency of W cycles. It also covers back-pressure: a full chain must refuse a fourth word until the far end acknowledges. Finally, the stalled operator must hold back its request for as long as it is paused.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Dual-rail pair encoding {true, false}; precharge drives both rails high.
  typedef enum logic [1:0] {
    DR_NULL = 2'b11,
    DR_ONE  = 2'b10,
    DR_ZERO = 2'b01
  } dr_pair_e;

  function automatic dr_pair_e dr_encode(input logic v);
    return v ? DR_ONE : DR_ZERO;
  endfunction

endpackage

// File: rtl/hs_dr_operator.sv
module hs_dr_operator
  import hs_pkg::*;
#(
  parameter int          W   = 8,
  parameter logic [W-1:0] KEY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval,
  input  logic         slow,
  input  logic [W-1:0] operand,
  output logic [W-1:0] rail_p,
  output logic [W-1:0] rail_n
);

  localparam int IW = $clog2(W + 1);

  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  p_d, n_d;
  logic [W-1:0]  result;
  logic          upd_en;
  logic          all_done;

  assign result   = operand ^ KEY;
  assign all_done = (idx_q == IW'(W));
  assign upd_en   = !eval || (!slow && !all_done);

  always_comb begin
    p_d   = rail_p;
    n_d   = rail_n;
    idx_d = idx_q;
    if (!eval) begin
      p_d   = '1;
      n_d   = '1;
      idx_d = '0;
    end else if (!slow && !all_done) begin
      for (int i = 0; i < W; i++) begin
        if (idx_q == IW'(i)) begin
          {p_d[i], n_d[i]} = dr_encode(result[i]);
        end
      end
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_p <= '1;
      rail_n <= '1;
      idx_q  <= '0;
    end else if (upd_en) begin
      rail_p <= p_d;
      rail_n <= n_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/hs_completion.sv
module hs_completion #(
  parameter int W = 8
) (
  input  logic [W-1:0] rail_p,
  input  logic [W-1:0] rail_n,
  output logic         ready,
  output logic         precharged
);

  assign ready      = &(rail_p ^ rail_n);
  assign precharged = &(rail_p & rail_n);

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic ack_in,
  input  logic ready,
  input  logic precharged,
  output logic ack_out,
  output logic req_out,
  output logic eval,
  output logic latch_en
);

  logic ack_d, req_d, eval_d;
  logic join_ok, req_set, req_clr, ack_clr, eval_clr;

  // Three-way join: upstream asks, own operator idle, downstream drained.
  assign join_ok  = req_in && !ack_out && !eval && precharged && !req_out && !ack_in;
  assign latch_en = join_ok;

  assign req_set  = eval && ready && !req_out && !ack_in;
  assign req_clr  = req_out && ack_in && !eval && precharged;
  assign ack_clr  = ack_out && !req_in;
  assign eval_clr = eval && req_out && ack_in;

  always_comb begin
    ack_d  = ack_out;
    req_d  = req_out;
    eval_d = eval;
    if (join_ok)       ack_d  = 1'b1;
    else if (ack_clr)  ack_d  = 1'b0;
    if (join_ok)       eval_d = 1'b1;
    else if (eval_clr) eval_d = 1'b0;
    if (req_set)       req_d  = 1'b1;
    else if (req_clr)  req_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_out <= 1'b0;
      req_out <= 1'b0;
      eval    <= 1'b0;
    end else begin
      ack_out <= ack_d;
      req_out <= req_d;
      eval    <= eval_d;
    end
  end

endmodule

// File: rtl/hs_pipe_stage.sv
module hs_pipe_stage #(
  parameter int           W   = 8,
  parameter logic [W-1:0] KEY = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_in,
  output logic         ack_out,
  input  logic [W-1:0] data_in,
  output logic         req_out,
  input  logic         ack_in,
  output logic [W-1:0] data_out,
  input  logic         op_slow,
  output logic         latch_en,
  output logic         op_eval,
  output logic         op_ready
);

  logic [1:0]   rst_sync_q;
  logic         core_rst_n;
  logic [W-1:0] operand_q;
  logic [W-1:0] rail_p, rail_n;
  logic         precharged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   operand_q <= '0;
    else if (latch_en) operand_q <= data_in;
  end

  hs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .req_in     (req_in),
    .ack_in     (ack_in),
    .ready      (op_ready),
    .precharged (precharged),
    .ack_out    (ack_out),
    .req_out    (req_out),
    .eval       (op_eval),
    .latch_en   (latch_en)
  );

  hs_dr_operator #(.W(W), .KEY(KEY)) u_op (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .eval    (op_eval),
    .slow    (op_slow),
    .operand (operand_q),
    .rail_p  (rail_p),
    .rail_n  (rail_n)
  );

  hs_completion #(.W(W)) u_done (
    .rail_p     (rail_p),
    .rail_n     (rail_n),
    .ready      (op_ready),
    .precharged (precharged)
  );

  assign data_out = rail_p;

endmodule

// File: rtl/hs_stage_checker.sv
module hs_stage_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_in,
  input logic         ack_out,
  input logic         req_out,
  input logic         ack_in,
  input logic         latch_en,
  input logic         op_eval,
  input logic         op_ready,
  input logic         op_slow,
  input logic [W-1:0] rail_p,
  input logic [W-1:0] rail_n
);

  logic all_pre;
  assign all_pre = &(rail_p & rail_n);

  a_r2_join_only: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> (req_in && !ack_out && !req_out && !ack_in && !op_eval && all_pre));

  a_r3_ack_eval_follow: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> (ack_out && op_eval));

  a_r4_req_rise_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> ($past(op_ready) && !$past(ack_in)));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && !ack_in) |=> req_out);

  a_r6_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_out) |-> ($past(ack_in) && $past(all_pre)));

  a_r7_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> !$past(req_in));

  a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out && req_in) |=> ack_out);

  a_r8_no_null_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (~rail_p & ~rail_n) == '0);

  a_r8_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rail_p) ^ $past(rail_n)) & (rail_p ^ rail_n) & (rail_p ^ $past(rail_p))) == '0);

  a_r9_slow_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (op_slow && op_eval) |=> ($stable(rail_p) && $stable(rail_n)));

endmodule

bind hs_pipe_stage hs_stage_checker #(.W(W)) u_hs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_in   (req_in),
  .ack_out  (ack_out),
  .req_out  (req_out),
  .ack_in   (ack_in),
  .latch_en (latch_en),
  .op_eval  (op_eval),
  .op_ready (op_ready),
  .op_slow  (op_slow),
  .rail_p   (rail_p),
  .rail_n   (rail_n)
);

// File: tb/hs_pipe_stage_bench.sv
module hs_pipe_stage_bench;

  localparam int W  = 8;
  localparam int NS = 3;
  localparam logic [W-1:0] KEYS [NS] = '{8'h5A, 8'hC3, 8'h0F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          src_req = 1'b0;
  logic [W-1:0]  src_data = '0;
  logic          snk_ack = 1'b0;
  logic          snk_hold = 1'b0;
  logic [NS-1:0] slow = '0;
  logic [NS-1:0] slow_force = '0;
  logic          slow_rand = 1'b0;

  logic          req_i [NS];
  logic          ack_i [NS];
  logic [W-1:0]  din   [NS];
  logic          req_o [NS];
  logic          ack_o [NS];
  logic [W-1:0]  dout  [NS];
  logic          latch [NS];
  logic          evalv [NS];
  logic          ready [NS];

  for (genvar s = 0; s < NS; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign req_i[s] = src_req;
      assign din[s]   = src_data;
    end else begin : g_mid
      assign req_i[s] = req_o[s-1];
      assign din[s]   = dout[s-1];
    end
    if (s == NS - 1) begin : g_tail
      assign ack_i[s] = snk_ack;
    end else begin : g_link
      assign ack_i[s] = ack_o[s+1];
    end
    hs_pipe_stage #(.W(W), .KEY(KEYS[s])) u_hs_pipe_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_in   (req_i[s]),
      .ack_out  (ack_o[s]),
      .data_in  (din[s]),
      .req_out  (req_o[s]),
      .ack_in   (ack_i[s]),
      .data_out (dout[s]),
      .op_slow  (slow[s]),
      .latch_en (latch[s]),
      .op_eval  (evalv[s]),
      .op_ready (ready[s])
    );
  end

  int errors = 0;
  int checks = 0;
  int tx_count = 0;
  int rx_count = 0;
  logic [W-1:0] expq [$];

  function automatic logic [W-1:0] chain_result(input logic [W-1:0] x);
    logic [W-1:0] v = x;
    for (int s = 0; s < NS; s++) v = v ^ KEYS[s];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Operator delay environment
  initial begin
    forever begin
      @(negedge clk);
      for (int s = 0; s < NS; s++)
        slow[s] = slow_force[s] | (slow_rand & ($urandom_range(0, 3) == 0));
    end
  end

  // Sink: four-phase consumer with random delays
  initial begin
    logic [W-1:0] exp_v;
    logic [W-1:0] seen;
    forever begin
      @(negedge clk);
      if (snk_hold || !req_o[NS-1]) continue;
      chk(ready[NS-1], "R5 ready while requesting", ready[NS-1], 1);
      seen = dout[NS-1];
      if (expq.size() == 0) begin
        chk(0, "R10 unexpected word", seen, 0);
        exp_v = seen;
      end else begin
        exp_v = expq.pop_front();
        chk(seen == exp_v, "R10 order and value", seen, exp_v);
      end
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk(req_o[NS-1] && dout[NS-1] == seen, "R4 request and data held", dout[NS-1], seen);
      end
      snk_ack = 1'b1;
      @(negedge clk);
      chk(req_o[NS-1] == 1'b1, "R6 request not dropped early", req_o[NS-1], 1);
      while (req_o[NS-1]) @(negedge clk);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      snk_ack = 1'b0;
      rx_count++;
    end
  end

  task automatic send(input logic [W-1:0] x, input int pre, input int hold);
    src_data = x;
    expq.push_back(chain_result(x));
    tx_count++;
    repeat (pre) @(negedge clk);
    src_req = 1'b1;
    do @(negedge clk); while (!ack_o[0]);
    repeat (hold) begin
      @(negedge clk);
      chk(ack_o[0] == 1'b1, "R7 ack held while request high", ack_o[0], 1);
    end
    src_req = 1'b0;
    do @(negedge clk); while (ack_o[0]);
  endtask

  task automatic drain();
    while (rx_count != tx_count) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int s = 0; s < NS; s++) begin
      chk(!ack_o[s] && !req_o[s] && !latch[s] && !evalv[s] && !ready[s],
          "R1 idle controls", {ack_o[s], req_o[s], latch[s], evalv[s], ready[s]}, 0);
      chk(dout[s] == '1, "R1 precharged rails", dout[s], 8'hFF);
    end

    // Latency with no stalls
    src_data = 8'h96;
    expq.push_back(chain_result(8'h96));
    tx_count++;
    src_req = 1'b1;
    do @(negedge clk); while (!evalv[0]);
    chk(ack_o[0] == 1'b1, "R3 ack with evaluation start", ack_o[0], 1);
    n = 0;
    while (!ready[0]) begin
      @(negedge clk);
      n++;
    end
    chk(n == W, "R9 evaluation latency", n, W);
    chk(dout[0] == (8'h96 ^ KEYS[0]), "R5 single stage result", dout[0], 8'h96 ^ KEYS[0]);
    src_req = 1'b0;
    do @(negedge clk); while (ack_o[0]);
    drain();

    // Stalled middle operator
    slow_force = 3'b010;
    send(8'h3C, 0, 0);
    repeat (30) @(negedge clk);
    chk(!req_o[1] && !ready[1], "R9 stalled operator holds request", {req_o[1], ready[1]}, 0);
    slow_force = '0;
    drain();

    // Back-pressure: chain full, fourth word refused
    snk_hold = 1'b1;
    send(8'h01, 0, 1);
    send(8'hFE, 1, 0);
    send(8'h80, 0, 2);
    src_data = 8'h7F;
    expq.push_back(chain_result(8'h7F));
    tx_count++;
    src_req = 1'b1;
    repeat (40) @(negedge clk);
    chk(ack_o[0] == 1'b0, "R2 no accept while stage busy", ack_o[0], 0);
    snk_hold = 1'b0;
    do @(negedge clk); while (!ack_o[0]);
    src_req = 1'b0;
    do @(negedge clk); while (ack_o[0]);
    drain();

    // Random traffic with random operator delays
    slow_rand = 1'b1;
    for (int k = 0; k < 40; k++)
      send(W'($urandom), $urandom_range(0, 3), $urandom_range(0, 3));
    slow_rand = 1'b0;
    drain();

    for (int s = 0; s < NS; s++)
      chk(dout[s] == '1 && !ready[s], "R8 rails back to precharge", dout[s], 8'hFF);
    chk(rx_count == tx_count && expq.size() == 0, "R10 all words delivered", rx_count, tx_count);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired R10 actual=%0d expected=%0d", rx_count, tx_count);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule